// File: doc/BRIEF.md
# Dual-Mode Interval Counter with Timeout

One instance sits beside each analog storage cell and turns a pair of pulse events into a digital time value. Three one-cycle event strobes reach the block: a discriminator hit, a peak-found strobe, and a readout strobe that marks when the cell is handed to the output. A mode input picks which pair bounds the measurement. In rise mode the interval runs from the hit to the peak. In arrival mode it runs from the peak to the readout.

The counter advances once every 1, 2, 4 or 8 clock cycles, as set by a scale field, and this sets the time resolution. It saturates rather than wrapping. A programmable limit gives a timing cut. When the running value passes the limit, a sticky reject flag is raised so that the pulse can be discarded, for example on a slow rise or a late readout. When the closing event arrives, the block raises done and freezes the count. It then waits for a clear before it will measure again.

Top module: `span_timer`

## Requirements
- R1: After reset, and on the cycle after `clr` is sampled high, `count` is 0, `done` is 0 and `reject` is 0.
- R2: With `mode`=0 (rise), a sampled `ev_hit` opens the interval and a later sampled `ev_peak` closes it. If the two are sampled N clock edges apart, the final `count` is N/D rounded down. `ev_read` has no effect in this mode.
- R3: With `mode`=1 (arrival), a sampled `ev_peak` opens the interval and a later sampled `ev_read` closes it, with the same N/D result. `ev_hit` has no effect in this mode.
- R4: The divisor is D = 2^`scale`, so `scale` values 0, 1, 2 and 3 give divisors 1, 2, 4 and 8. The prescaler restarts with each opening event.
- R5: `count` never decreases except on clear. It saturates at 4095 (all ones at the default 12-bit width) and holds there.
- R6: `reject` rises on the same edge on which `count` first becomes greater than `limit`. It stays high through done until clear. It never rises while `count` is at or below `limit`.
- R7: A closing event that arrives while the block is idle is ignored: `count` stays 0 and `done` stays 0. If the opening and closing events are sampled on the same edge while idle, only the opening event takes effect.
- R8: `done` rises on the edge that samples the closing event. While `done` is high, `done` and `count` hold, and all events are ignored until clear.
- R9: `clr` takes priority over every event on the same edge, including a closing event in mid-measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous return to idle with zero count |
| mode | input | 1 | 0 = hit-to-peak, 1 = peak-to-readout |
| scale | input | 2 | Prescaler select; the divisor is 2^scale |
| limit | input | 12 | Reject threshold; the pulse is rejected when the count exceeds it |
| ev_hit | input | 1 | Discriminator hit strobe |
| ev_peak | input | 1 | Peak-found strobe |
| ev_read | input | 1 | Cell-presented-for-readout strobe |
| count | output | 12 | Measured interval in prescaled ticks |
| done | output | 1 | Measurement closed; count frozen |
| reject | output | 1 | Sticky timing-limit violation flag |

## Verification
The properties assume that `mode`, `scale` and `limit` stay constant from the opening event until the following clear. The reject check in particular compares `count` against the `limit` of the same cycle. The stimulus changes these three inputs only while the block is idle after a clear. Inside that envelope it randomizes the interval length, the scale and the limit, and it fires the unused and repeated event strobes at random while a measurement runs and while it is held.

// File: rtl/span_timer_pkg.sv
package span_timer_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_HELD = 2'd2
   } span_state_e;
endpackage

// File: rtl/span_event_sel.sv
module span_event_sel (
   input  logic mode,
   input  logic ev_hit,
   input  logic ev_peak,
   input  logic ev_read,
   output logic start_ev,
   output logic stop_ev
);
   always_comb begin
      if (mode) begin
         start_ev = ev_peak;
         stop_ev  = ev_read;
      end else begin
         start_ev = ev_hit;
         stop_ev  = ev_peak;
      end
   end
endmodule

// File: rtl/span_prescale.sv
module span_prescale #(
   parameter int SCALE_W = 2
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 restart,
   input  logic                                 run,
   input  logic [((SCALE_W > 0) ? SCALE_W : 1)-1:0] scale,
   output logic                                 tick
);
   localparam int SEL_W = (SCALE_W > 0) ? SCALE_W : 1;
   localparam int PRE_W = ((1 << SCALE_W) - 1 > 0) ? (1 << SCALE_W) - 1 : 1;

   generate
      if (SCALE_W == 0) begin : g_direct
         logic unused_w;
         assign unused_w = &{1'b0, clk, rst_n, restart, scale};
         assign tick = run;
      end else begin : g_divided
         logic [PRE_W-1:0] pre_q;
         logic [PRE_W-1:0] mask;

         always_comb begin
            for (int i = 0; i < PRE_W; i++) begin
               mask[i] = (32'(i) < 32'(scale));
            end
         end

         assign tick = run && (pre_q == mask);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (restart) begin
               pre_q <= '0;
            end else if (run) begin
               if (tick) pre_q <= '0;
               else      pre_q <= pre_q + 1'b1;
            end
         end

         if (SEL_W > 5) begin : g_bad_sel
            $error("span_prescale: SCALE_W too large");
         end
      end
   endgenerate
endmodule

// File: rtl/span_count.sv
module span_count #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             inc,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] count,
   output logic             reject
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic             rej_q;

   assign cnt_nxt = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rej_q <= 1'b0;
      end else if (clear) begin
         cnt_q <= '0;
         rej_q <= 1'b0;
      end else if (inc) begin
         cnt_q <= cnt_nxt;
         if (cnt_nxt > limit) rej_q <= 1'b1;
      end
   end

   assign count  = cnt_q;
   assign reject = rej_q;
endmodule

// File: rtl/span_timer.sv
module span_timer
   import span_timer_pkg::*;
#(
   parameter int CNT_W   = 12,
   parameter int SCALE_W = 2
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 clr,
   input  logic                                 mode,
   input  logic [((SCALE_W > 0) ? SCALE_W : 1)-1:0] scale,
   input  logic [CNT_W-1:0]                     limit,
   input  logic                                 ev_hit,
   input  logic                                 ev_peak,
   input  logic                                 ev_read,
   output logic [CNT_W-1:0]                     count,
   output logic                                 done,
   output logic                                 reject
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("span_timer: CNT_W must lie in 2..32");
      end
      if (SCALE_W < 0 || SCALE_W > 4) begin : g_bad_scale
         $error("span_timer: SCALE_W must lie in 0..4");
      end
   endgenerate

   span_state_e st_q;
   logic        start_w;
   logic        stop_w;
   logic        tick_w;
   logic        run_w;
   logic        open_w;

   span_event_sel u_sel (
      .mode     (mode),
      .ev_hit   (ev_hit),
      .ev_peak  (ev_peak),
      .ev_read  (ev_read),
      .start_ev (start_w),
      .stop_ev  (stop_w)
   );

   assign run_w  = (st_q == ST_RUN);
   assign open_w = (st_q == ST_IDLE) && start_w;

   span_prescale #(.SCALE_W(SCALE_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (!run_w || clr),
      .run     (run_w),
      .scale   (scale),
      .tick    (tick_w)
   );

   span_count #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (clr || open_w),
      .inc    (tick_w),
      .limit  (limit),
      .count  (count),
      .reject (reject)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
      end else if (clr) begin
         st_q <= ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start_w) st_q <= ST_RUN;
            ST_RUN:  if (stop_w)  st_q <= ST_HELD;
            ST_HELD: st_q <= ST_HELD;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign done = (st_q == ST_HELD);
endmodule

// File: rtl/span_timer_chk.sv
module span_timer_chk
   import span_timer_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic [CNT_W-1:0] limit,
   input logic [CNT_W-1:0] count,
   input logic             done,
   input logic             reject,
   input span_state_e      st,
   input logic             start_ev
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0 && !done && !reject));

   p_monotonic_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (count >= $past(count)));

   p_saturate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_MAX && !clr) |=> (count == CNT_MAX));

   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reject && !clr) |=> reject);

   p_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reject) |-> (count > limit));

   p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !start_ev && !clr) |=> (count == '0 && !done));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clr) |=> (done && $stable(count)));
endmodule

bind span_timer span_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr      (clr),
   .limit    (limit),
   .count    (count),
   .done     (done),
   .reject   (reject),
   .st       (st_q),
   .start_ev (start_w)
);

// File: tb/span_timer_bench.sv
module span_timer_bench;
   localparam int MAXC = 4095;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        mode = 1'b0;
   logic [1:0]  scale = 2'd0;
   logic [11:0] limit = 12'd0;
   logic        ev_hit = 1'b0;
   logic        ev_peak = 1'b0;
   logic        ev_read = 1'b0;
   logic [11:0] count;
   logic        done;
   logic        reject;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   span_timer u_span_timer (
      .clk(clk), .rst_n(rst_n), .clr(clr), .mode(mode), .scale(scale),
      .limit(limit), .ev_hit(ev_hit), .ev_peak(ev_peak), .ev_read(ev_read),
      .count(count), .done(done), .reject(reject)
   );

   function automatic int exp_count(int n, int sc);
      int v = n >> sc;
      return (v > MAXC) ? MAXC : v;
   endfunction

   task automatic check(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic quiet();
      ev_hit = 1'b0; ev_peak = 1'b0; ev_read = 1'b0;
   endtask

   task automatic put_start(bit m);
      if (m) ev_peak = 1'b1; else ev_hit = 1'b1;
   endtask

   task automatic put_stop(bit m);
      if (m) ev_read = 1'b1; else ev_peak = 1'b1;
   endtask

   task automatic put_noise(bit m);
      ev_hit = 1'($urandom % 2);
      if (m) ev_peak = 1'($urandom % 2);
      else   ev_read = 1'($urandom % 2);
   endtask

   task automatic do_clear(string req);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      check({req, " count"},  int'(count),  0);
      check({req, " done"},   int'(done),   0);
      check({req, " reject"}, int'(reject), 0);
   endtask

   task automatic measure(bit m, int sc, int lim, int n, bit noise, string req);
      int ec;
      mode = m; scale = 2'(sc); limit = 12'(lim);
      // closing event while idle: R7
      put_stop(m);
      @(negedge clk);
      quiet();
      check("R7 idle stop count", int'(count), 0);
      check("R7 idle stop done",  int'(done),  0);
      put_start(m);
      @(negedge clk);
      quiet();
      for (int i = 1; i < n; i++) begin
         if (noise) put_noise(m);
         @(negedge clk);
         quiet();
      end
      put_stop(m);
      @(negedge clk);
      quiet();
      ec = exp_count(n, sc);
      check({req, " R4 done"},  int'(done),   1);
      check({req, " R4 count"}, int'(count),  ec);
      check("R6 reject at close", int'(reject), (ec > lim) ? 1 : 0);
      // events while held: R8
      for (int i = 0; i < 3; i++) begin
         put_noise(m);
         put_start(m);
         if ($urandom % 2) put_stop(m);
         @(negedge clk);
         quiet();
      end
      check("R8 held done",  int'(done),  1);
      check("R8 held count", int'(count), ec);
      do_clear("R1 clear");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd24680));
      repeat (3) @(negedge clk);
      check("R1 reset count",  int'(count),  0);
      check("R1 reset done",   int'(done),   0);
      check("R1 reset reject", int'(reject), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed basics for both modes and every scale
      measure(1'b0, 0, 4095, 10, 1'b1, "R2 rise");
      measure(1'b1, 0, 4095, 10, 1'b1, "R3 arrival");
      measure(1'b0, 1, 4095, 11, 1'b0, "R2 div2");
      measure(1'b1, 2, 4095, 13, 1'b0, "R3 div4");
      measure(1'b0, 3, 4095, 31, 1'b1, "R2 div8");
      measure(1'b1, 3, 4095, 7,  1'b0, "R3 below one tick");
      measure(1'b0, 0, 4095, 1,  1'b0, "R2 shortest");

      // reject edge tracked cycle by cycle: R6
      mode = 1'b0; scale = 2'd0; limit = 12'd4;
      put_start(1'b0);
      @(negedge clk);
      quiet();
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         check("R6 running count",  int'(count),  k);
         check("R6 reject timing",  int'(reject), (k > 4) ? 1 : 0);
      end
      put_stop(1'b0);
      @(negedge clk);
      quiet();
      check("R6 reject kept at done", int'(reject), 1);
      do_clear("R1 clear after reject");

      // simultaneous open and close while idle: R7
      mode = 1'b0; scale = 2'd0; limit = 12'd4095;
      ev_hit = 1'b1; ev_peak = 1'b1;
      @(negedge clk);
      quiet();
      check("R7 same-edge open", int'(done), 0);
      repeat (4) @(negedge clk);
      put_stop(1'b0);
      @(negedge clk);
      quiet();
      check("R7 same-edge count", int'(count), 5);
      check("R7 same-edge done",  int'(done),  1);
      do_clear("R1 clear");

      // clear beats a closing event: R9
      mode = 1'b1;
      put_start(1'b1);
      @(negedge clk);
      quiet();
      repeat (5) @(negedge clk);
      put_stop(1'b1);
      clr = 1'b1;
      @(negedge clk);
      quiet();
      clr = 1'b0;
      check("R9 clear wins count", int'(count), 0);
      check("R9 clear wins done",  int'(done),  0);

      // saturation: R5
      measure(1'b1, 0, 4095, 4200, 1'b0, "R5 saturate");
      measure(1'b0, 0, 100,  4100, 1'b0, "R5 saturate reject");

      // constrained random
      for (int t = 0; t < 60; t++) begin
         measure(1'($urandom % 2), int'($urandom % 4), int'($urandom % 80),
                 1 + int'($urandom % 300), 1'b1, "R2 R3 random");
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule